// File: doc/BRIEF.md
# Timer Prescaler Reset Synchronization Controller

This block is an 8-bit control register that governs the reset of two timer prescalers. The first prescaler runs on the system clock and is shared by several timers. The second prescaler lives in a separate, asynchronous clock domain. Software can request a one-shot reset of either prescaler.

A hold mode keeps both resets asserted. While they are held, several timers can be loaded with the same start value. Leaving hold mode releases every timer in the same cycle, so they start counting together.

The reset of the shared prescaler lasts a single clock. The reset of the asynchronous-domain prescaler uses a request/acknowledge handshake through two-flop synchronizers in both directions. Its request bit stays readable as 1 until the acknowledge returns.

A 10-bit free-running divider is included as the shared prescaler. It gives divide taps at /8, /64, /256 and /1024, so the effect of its reset can be seen at the ports.

Top module: `prescaler_sync_ctrl`

## Requirements
- R1: After reset the register reads 0x00, both prescaler reset outputs are low and the divider count starts at 0.
- R2: Bits 6:2 always read as 0, and writing ones to them changes no other bit.
- R3: `rd_data` shows the register as {hold, 5'b0, async request, sync request} while `rd_en` is 1, and shows 0x00 while `rd_en` is 0.
- R4: With hold at 0, writing 1 to bit 0 drives `sync_psc_rst` high for exactly the one cycle after the write edge. Bit 0 reads 0 from the following cycle.
- R5: With hold at 0, writing 1 to bit 1 keeps bit 1 at 1 until `async_psc_rst` has been asserted in the async domain and the acknowledge has returned. The bit then clears by itself. A new request made while the previous acknowledge is still high also completes.
- R6: While hold (bit 7) is 1, the values written to bits 1 and 0 are kept, and the matching reset outputs stay asserted for as long as hold stays at 1.
- R7: A single write that sets hold and a reset bit together keeps that reset asserted continuously from the cycle after the write.
- R8: A write with bit 7 = 0 while hold is 1 clears hold, bit 1 and bit 0 at the same edge, whatever the data in bits 1:0.
- R9: While `sync_psc_rst` is high the divider count is held at 0 and all taps are low. Afterwards tap i pulses for one cycle whenever the low W bits of the count are all ones, with W = 3, 6, 8, 10 for taps 0..3. The first pulses therefore come 8, 64, 256 and 1024 cycles after the reset cycle.
- R10: Counters clocked from the taps keep their loaded values during hold and advance together after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, clk domain |
| aclk | input | 1 | Clock of the asynchronous prescaler domain |
| arst_n | input | 1 | Synchronous active-low reset, aclk domain |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Read data (0 when not reading) |
| sync_psc_rst | output | 1 | Reset to the shared synchronous prescaler |
| async_psc_rst | output | 1 | Reset to the async-domain prescaler, aclk domain |
| tap_tick | output | 4 | Divider tap pulses (/8, /64, /256, /1024) |

## Verification
Two events can land on the same clock edge and must be resolved correctly.

The first is a write that enters hold mode together with a reset bit. The bench writes 0x83 and requires both reset outputs to stay high and every tap to stay silent for dozens of cycles. It also requires the register to still read 0x83 after the acknowledge has come back.

The second is a new async request that arrives while the previous acknowledge is still high. The bench issues a new request on the cycle right after the previous one clears. It then requires `async_psc_rst` to be seen rising again before the bit clears a second time.

// File: rtl/psc_pkg.sv
// Shared constants for the prescaler reset controller.
// Assumes an 8-bit control register with fixed bit positions.
package psc_pkg;
    localparam int REG_W    = 8;
    localparam int HOLD_BIT = 7;
    localparam int AREQ_BIT = 1;
    localparam int SREQ_BIT = 0;

    // Width of the all-ones match for divider tap idx.
    function automatic int tap_width(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction
endpackage

// File: rtl/psc_ctrl_reg.sv
// Control register: hold mode, sync reset request, async reset request.
// Assumes ack_s is already synchronized to clk.
// Reserved bits are not stored.
module psc_ctrl_reg
    import psc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic             ack_s,
    output logic [REG_W-1:0] rd_data,
    output logic             sreq,
    output logic             areq_drive,
    output logic             hold_q
);
    logic areq;
    logic ack_q;
    logic ack_rise;
    logic unused_rsvd;

    assign unused_rsvd = ^wr_data[HOLD_BIT-1:AREQ_BIT+1];
    assign ack_rise    = ack_s & ~ack_q;

    // Edge detector on the returned acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= ack_s;
    end

    // Register update: write, hold keep, release clear, hardware clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            sreq   <= 1'b0;
            areq   <= 1'b0;
        end else if (wr_en) begin
            hold_q <= wr_data[HOLD_BIT];
            if (hold_q && !wr_data[HOLD_BIT]) begin
                sreq <= 1'b0;
                areq <= 1'b0;
            end else if (hold_q) begin
                sreq <= wr_data[SREQ_BIT];
                areq <= wr_data[AREQ_BIT];
            end else begin
                sreq <= wr_data[SREQ_BIT];
                areq <= wr_data[AREQ_BIT] | (areq & ~ack_rise);
            end
        end else if (!hold_q) begin
            sreq <= 1'b0;
            if (ack_rise) areq <= 1'b0;
        end
    end

    // Drop the request while a stale acknowledge is still high (outside hold).
    assign areq_drive = areq & ~(ack_s & ~hold_q);

    // Read path, zero when not selected.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            rd_data[HOLD_BIT] = hold_q;
            rd_data[AREQ_BIT] = areq;
            rd_data[SREQ_BIT] = sreq;
        end
    end

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[HOLD_BIT-1:AREQ_BIT+1] == '0);
    // R4
    sync_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_q && !wr_en) |=> !sreq);
    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !wr_en) |=> ($stable(sreq) && $stable(areq) && hold_q));
    // R8
    release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hold_q && !wr_data[HOLD_BIT]) |=> (!sreq && !areq && !hold_q));
    // R5
    async_wait_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (areq && !ack_s && !wr_en) |=> areq);
endmodule

// File: rtl/psc_async_link.sv
// Request/acknowledge crossing to the async prescaler domain.
// Assumes req is a clk-domain level held until the acknowledge returns.
// Two flops are used in each direction.
module psc_async_link (
    input  logic clk,
    input  logic rst_n,
    input  logic aclk,
    input  logic arst_n,
    input  logic req,
    output logic ack_s,
    output logic a_rst
);
    logic a_s1;
    logic k_s1;

    // Bring the request into the aclk domain; the second stage is the reset.
    always_ff @(posedge aclk) begin
        if (!arst_n) begin
            a_s1  <= 1'b0;
            a_rst <= 1'b0;
        end else begin
            a_s1  <= req;
            a_rst <= a_s1;
        end
    end

    // Return the applied reset to clk as the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_s1  <= 1'b0;
            ack_s <= 1'b0;
        end else begin
            k_s1  <= a_rst;
            ack_s <= k_s1;
        end
    end
endmodule

// File: rtl/psc_divider.sv
// Shared synchronous prescaler: free-running counter with all-ones taps.
// Assumes psc_rst is a synchronous clear.
module psc_divider
    import psc_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int N_TAPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psc_rst,
    output logic [N_TAPS-1:0] tick
);
    logic [CNT_W-1:0] count;

    // Count up, clear on either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || psc_rst) count <= '0;
        else                   count <= count + 1'b1;
    end

    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        localparam int TW_RAW = tap_width(g);
        localparam int TW     = (TW_RAW > CNT_W) ? CNT_W : TW_RAW;
        assign tick[g] = (&count[TW-1:0]) & ~psc_rst;
    end

    // R9
    clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psc_rst |=> (count == '0));
    // R9
    tap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psc_rst |-> (tick == '0));
endmodule

// File: rtl/prescaler_sync_ctrl.sv
// Top: control register, async handshake and shared divider.
// Assumes clk and aclk are unrelated; only async_psc_rst is in the aclk domain.
module prescaler_sync_ctrl
    import psc_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int N_TAPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aclk,
    input  logic              arst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rd_data,
    output logic              sync_psc_rst,
    output logic              async_psc_rst,
    output logic [N_TAPS-1:0] tap_tick
);
    logic ack_s;
    logic areq_drive;
    logic hold_q;

    psc_ctrl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .ack_s      (ack_s),
        .rd_data    (rd_data),
        .sreq       (sync_psc_rst),
        .areq_drive (areq_drive),
        .hold_q     (hold_q)
    );

    psc_async_link u_link (
        .clk    (clk),
        .rst_n  (rst_n),
        .aclk   (aclk),
        .arst_n (arst_n),
        .req    (areq_drive),
        .ack_s  (ack_s),
        .a_rst  (async_psc_rst)
    );

    psc_divider #(.CNT_W(CNT_W), .N_TAPS(N_TAPS)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .psc_rst (sync_psc_rst),
        .tick    (tap_tick)
    );

    // R7
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && sync_psc_rst && !wr_en) |=> sync_psc_rst);
endmodule

// File: tb/prescaler_sync_ctrl_bench.sv
// Scoreboard bench: register reads are queued with their expected value by a
// driver task and compared by a monitor; other checks are direct.
module prescaler_sync_ctrl_bench;
    logic       clk = 1'b0;
    logic       aclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       sb_en = 1'b0;
    logic [7:0] rd_data;
    logic       sync_psc_rst;
    logic       async_psc_rst;
    logic [3:0] tap_tick;

    int total = 0;
    int fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    // Bench timers fed from the taps.
    logic       ld = 1'b0;
    int         ca = 0;
    int         cb = 0;

    always #2.5 clk = ~clk;
    always #3.5 aclk = ~aclk;

    prescaler_sync_ctrl u_prescaler_sync_ctrl (
        .clk(clk), .rst_n(rst_n), .aclk(aclk), .arst_n(arst_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .sync_psc_rst(sync_psc_rst), .async_psc_rst(async_psc_rst),
        .tap_tick(tap_tick)
    );

    always @(posedge clk) begin
        if (ld) begin
            ca <= 5;
            cb <= 100;
        end else begin
            if (tap_tick[0]) ca <= ca + 1;
            if (tap_tick[1]) cb <= cb + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(posedge clk); #1 wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1 wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd_expect(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1 rd_en = 1'b1; sb_en = 1'b1;
        @(posedge clk); #1 rd_en = 1'b0; sb_en = 1'b0;
    endtask

    // Monitor: pop and compare each scheduled read.
    always @(negedge clk) begin
        if (sb_en && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, int'(rd_data), int'(e));
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        total++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        int first[4];
        int saw;
        int clr;
        int fell;

        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1; arst_n = 1'b1;
        @(posedge clk); #2;
        // R1 reset state
        chk("R1 sync_psc_rst", sync_psc_rst, 0);
        chk("R1 async_psc_rst", async_psc_rst, 0);
        chk("R3 idle rd_data", rd_data, 0);
        rd_expect(8'h00, "R1 reset readback");

        // R2 reserved bits ignored
        wr(8'h7C);
        rd_expect(8'h00, "R2 reserved write");

        // R4 one-cycle sync reset, R9 tap timing
        wr(8'h01);
        #1 chk("R4 pulse high", sync_psc_rst, 1);
        chk("R9 taps quiet in reset", tap_tick, 0);
        for (int i = 0; i < 4; i++) first[i] = 0;
        for (int j = 1; j <= 1100; j++) begin
            @(posedge clk); #2;
            if (j == 1) chk("R4 pulse ended", sync_psc_rst, 0);
            for (int i = 0; i < 4; i++)
                if (tap_tick[i] && first[i] == 0) first[i] = j;
        end
        chk("R9 tap0 first", first[0], 8);
        chk("R9 tap1 first", first[1], 64);
        chk("R9 tap2 first", first[2], 256);
        chk("R9 tap3 first", first[3], 1024);
        rd_expect(8'h00, "R4 bit self-cleared");

        // R7 hold with both resets in one write; R6 kept; R10 counters halted
        wr(8'h83);
        @(posedge clk); #1 ld = 1'b1;
        @(posedge clk); #1 ld = 1'b0;
        saw = 1;
        for (int j = 0; j < 40; j++) begin
            @(posedge clk); #2;
            if (!sync_psc_rst || tap_tick != 0) saw = 0;
        end
        chk("R7 sync held continuously", saw, 1);
        chk("R6 async held", async_psc_rst, 1);
        chk("R10 counter a halted", ca, 5);
        chk("R10 counter b halted", cb, 100);
        rd_expect(8'h83, "R6 bits kept in hold");
        #1 chk("R3 no read strobe", rd_data, 0);
        wr(8'hFF);
        rd_expect(8'h83, "R2 reserved ignored in hold");

        // R8 release clears both bits; R10 lockstep start
        wr(8'h03);
        #1 chk("R8 sync released", sync_psc_rst, 0);
        repeat (80) @(posedge clk);
        #2 chk("R10 counter a advanced", ca, 15);
        chk("R10 counter b advanced", cb, 101);
        rd_expect(8'h00, "R8 release readback");
        chk("R8 async dropped", async_psc_rst, 0);

        // R5 async handshake
        wr(8'h02);
        #1 rd_en = 1'b1;
        #1 chk("R5 pending after write", rd_data[1], 1);
        saw = 0; clr = 0;
        for (int j = 0; j < 40 && clr == 0; j++) begin
            @(posedge clk); #2;
            if (async_psc_rst) saw = 1;
            if (!rd_data[1]) clr = 1;
        end
        chk("R5 reset applied before clear", saw, 1);
        chk("R5 bit cleared", clr, 1);
        // R5 back-to-back request during acknowledge tail
        rd_en = 1'b0;
        wr(8'h02);
        #1 rd_en = 1'b1;
        saw = 0; clr = 0; fell = 0;
        for (int j = 0; j < 60 && clr == 0; j++) begin
            @(posedge clk); #2;
            if (!async_psc_rst) fell = 1;
            if (fell && async_psc_rst) saw = 1;
            if (!rd_data[1]) clr = 1;
        end
        chk("R5 second reset reapplied", saw, 1);
        chk("R5 second bit cleared", clr, 1);
        rd_en = 1'b0;
        repeat (20) @(posedge clk);
        #2 chk("R5 async released", async_psc_rst, 0);

        summary();
    end
endmodule